// File: doc/BRIEF.md
# Two-Digit Ternary Counter

This block is a free-running synchronous counter made of two base-3 digits. The low digit (Y) steps on every rising clock edge through 0, 1, 2 and back to 0. The high digit (X) steps only on edges where the low digit is leaving 2. Together the two digits walk through all nine values 00 to 22 and then wrap to 00.

Each digit is held as a 2-bit binary code (0 = 00, 1 = 01, 2 = 10). Each code bit sits in a toggle-style storage element. AND/OR/NOT logic decides which bits flip on each edge. The only inputs are the clock and an active-low synchronous reset. A typical use is as a small sequencing or phase generator whose outputs are read directly as two base-3 digits.

Top module: `tern_counter2`

## Requirements
- R1: On any rising edge where `rst_n` is 0, both digits become 0 (all four outputs 0) after that edge.
- R2: With `rst_n` high, the low digit `{y_msb,y_lsb}` steps 00 -> 01 -> 10 -> 00 on successive rising edges.
- R3: The high digit `{x_msb,x_lsb}` advances by one (00 -> 01 -> 10 -> 00) only on an edge where the low digit was 10 just before the edge. On every other edge it holds its value.
- R4: Starting from 00, the pair XY takes the values 00, 01, 02, 10, 11, 12, 20, 21, 22 on successive edges and returns to 00 on the ninth edge.
- R5: Reset wins over counting. An edge with `rst_n` low yields 00 even when the counter was at a carry point such as XY = 12 or 22.
- R6: The code 11 never appears on either digit after reset. If a digit ever held 11, its next advance would take it to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x_msb | output | 1 | High digit, bit 1 |
| x_lsb | output | 1 | High digit, bit 0 |
| y_msb | output | 1 | Low digit, bit 1 |
| y_lsb | output | 1 | Low digit, bit 0 |

## Verification
Every result of this block, whether a count step, a carry into X or a reset, appears on the outputs exactly one rising edge after the stimulus. The stimulus is the value of `rst_n` and the current count at that edge. The driver records the expected digit pair right after each rising edge. The monitor compares it at the next falling edge, half a period later, before the driver changes `rst_n` again. Resets are applied at cold start, at the carry point XY = 12 and at the wrap point XY = 22, and each is followed by a fresh count.

// File: rtl/tern_pkg.sv
// Package: shared constants for the ternary counter.
// Assumes digit codes 0=00, 1=01, 2=10; code 11 is illegal.
package tern_pkg;
    localparam int DIGIT_W  = 2;
    localparam int N_DIGITS = 2;
    localparam logic [DIGIT_W-1:0] CODE_ZERO = 2'b00;
    localparam logic [DIGIT_W-1:0] CODE_ONE  = 2'b01;
    localparam logic [DIGIT_W-1:0] CODE_TWO  = 2'b10;
    localparam logic [DIGIT_W-1:0] CODE_BAD  = 2'b11;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/tern_tff.sv
// Module: bank of toggle flip-flops.
// Each bit flips on a rising edge when its toggle input is 1.
// A synchronous active-low reset clears the bank and wins over toggling.
module tern_tff #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tog,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, else flip the bits selected by tog.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q ^ tog;
    end

    // R1: reset clears the bank (this holds from time zero)
    a_r1_bank_clear: assert property (@(posedge clk) !rst_n |=> (q == '0));
endmodule

// File: rtl/tern_digit.sv
// Module: one base-3 digit stored in toggle flip-flops.
// It advances when adv_i is 1. The carry goes out when the digit wraps 2 -> 0.
// The illegal code 11 returns to 00 on its next advance, with no carry.
module tern_digit
    import tern_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv_i,
    output digit_t q_o,
    output logic   carry_o
);
    digit_t tog;

    // Purpose: toggle enables. Bit 0 flips except from 2; bit 1 flips from 1, 2 and 3.
    always_comb begin
        tog[0] = adv_i & ~(q_o[1] & ~q_o[0]);
        tog[1] = adv_i & (q_o[1] | q_o[0]);
    end

    // Purpose: carry to the next digit when this digit wraps from 2.
    always_comb carry_o = adv_i & q_o[1] & ~q_o[0];

    tern_tff #(.W(DIGIT_W)) u_bits (
        .clk  (clk),
        .rst_n(rst_n),
        .tog  (tog),
        .q    (q_o)
    );

    // R2/R3: one step of the digit on an advance
    a_r2_step01: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && q_o == CODE_ZERO) |=> (q_o == CODE_ONE));
    a_r2_step12: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && q_o == CODE_ONE) |=> (q_o == CODE_TWO));
    a_r2_step20: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && q_o == CODE_TWO) |=> (q_o == CODE_ZERO));
    // R3: the digit holds when it is not advanced
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(q_o));
    // R6: the illegal code never appears, and recovers if present
    a_r6_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        q_o != CODE_BAD);
    a_r6_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && q_o == CODE_BAD) |=> (q_o == CODE_ZERO));
endmodule

// File: rtl/tern_counter2.sv
// Module: two-digit base-3 counter. Digit index 0 is Y (low) and 1 is X (high).
// The low digit advances on every edge, and each higher digit advances on the
// carry of the digit below it. The reset is synchronous and active low.
module tern_counter2
    import tern_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic x_msb,
    output logic x_lsb,
    output logic y_msb,
    output logic y_lsb
);
    digit_t             dig   [N_DIGITS];
    logic [N_DIGITS:0]  carry;

    assign carry[0] = 1'b1;

    genvar i;
    generate
        for (i = 0; i < N_DIGITS; i++) begin : g_digit
            tern_digit u_dig (
                .clk    (clk),
                .rst_n  (rst_n),
                .adv_i  (carry[i]),
                .q_o    (dig[i]),
                .carry_o(carry[i+1])
            );
        end
    endgenerate

    // Purpose: map the digit codes to the output pins.
    always_comb begin
        {y_msb, y_lsb} = dig[0];
        {x_msb, x_lsb} = dig[1];
    end

    // R3: X moves only when Y is at 2
    a_r3_x_only_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ({y_msb, y_lsb} != CODE_TWO) |=> $stable({x_msb, x_lsb}));
    // R4: full wrap from 22 to 00
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        carry[N_DIGITS] |=> ({x_msb, x_lsb, y_msb, y_lsb} == 4'b0000));
endmodule

// File: tb/tb_tern_counter2.sv
// Bench: a scoreboard. The driver pushes the expected digit pair for each edge
// into a queue, and the monitor pops and compares it at the falling edge.
module tb_tern_counter2;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    ex;
        int    ey;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_msb, x_lsb, y_msb, y_lsb;

    int   n_run  = 0;
    int   n_fail = 0;
    int   ref_cnt = 0;
    exp_t sb[$];

    tern_counter2 dut (
        .clk  (clk),
        .rst_n(rst_n),
        .x_msb(x_msb),
        .x_lsb(x_lsb),
        .y_msb(y_msb),
        .y_lsb(y_lsb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply rst_n for one edge, then push the expected count.
    task automatic step(input logic r, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r;
        @(posedge clk);
        if (!r) ref_cnt = 0;
        else    ref_cnt = (ref_cnt + 1) % 9;
        e.ex  = ref_cnt / 3;
        e.ey  = ref_cnt % 3;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            int ax, ay;
            e  = sb.pop_front();
            ax = {30'd0, x_msb, x_lsb};
            ay = {30'd0, y_msb, y_lsb};
            n_run++;
            if (ax != e.ex || ay != e.ey) begin
                n_fail++;
                $display("FAIL %s: got XY=%0d%0d expected XY=%0d%0d", e.tag, ax, ay, e.ex, e.ey);
            end
            n_run++;
            if (ax == 3 || ay == 3) begin
                n_fail++;
                $display("FAIL R6: illegal code, got XY=%0d%0d expected no digit 3", ax, ay);
            end
        end
    end

    initial begin
        // R1: cold reset
        step(1'b0, "R1");
        step(1'b0, "R1");
        // R2 R3 R4: two full rounds of the sequence plus a few more edges
        for (int k = 0; k < 22; k++) begin
            if (k % 9 == 8) step(1'b1, "R4");
            else if (k % 3 == 2) step(1'b1, "R3");
            else step(1'b1, "R2");
        end
        // ref_cnt is now 22 mod 9 = 4 (XY=11); step to 5 (XY=12)
        step(1'b1, "R2");
        // R5: reset at a carry point (XY=12)
        step(1'b0, "R5");
        for (int k = 0; k < 8; k++) step(1'b1, "R4");
        // now at XY=22; R5: reset at the wrap point
        step(1'b0, "R5");
        for (int k = 0; k < 5; k++) step(1'b1, "R2");
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: count a hang as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule